// File: doc/BRIEF.md
# Ring Message Mail Stop

One node on a one-way ring of 48-bit slot registers that carries messages between processors. Every clock cycle the stop latches the slot word that arrives from the previous node and presents it to the next node one cycle later. A slot holds four fields. The most significant eight bits are control. The next twelve bits are the sender address, the next twelve are the destination, and the low sixteen bits are payload. In the control byte, bit 7 marks the slot as occupied and bits 1:0 select the delivery mode: 0 addressed, 1 single by pattern, 2 everyone, 3 group by pattern.

For each occupied slot the stop decides whether to take a copy. An addressed message matches when its destination equals the strapped node address. The two pattern modes match when the destination and a local pattern agree on every bit set in a local mask. The everyone mode always matches. Messages meant for a single receiver are removed from the ring once they are taken. Group and everyone messages are copied and passed on. When the sender's own group or everyone message comes back to it, the sender deletes it. A full receive register refuses new deliveries, and a refused message travels on unchanged.

The local processor reaches the stop through a window of sixteen 16-bit register locations. A message it writes there waits as pending until the outgoing slot is empty, and it is then placed on the ring with the valid bit set and the node address as sender.

Top module: `ring_mail_stop`

## Requirements
- R1: After reset, ring_o is all zeros, the status register (location 0) reads 0 and the pattern and mask registers (locations 9 and 10) read 0.
- R2: An occupied slot that is neither taken nor deleted appears unchanged on ring_o exactly one cycle after it is on ring_i.
- R3: An occupied mode-0 slot whose destination equals node_id_i is taken into the receive register when that register is empty, and the outgoing slot becomes all zeros.
- R4: An occupied mode-1 slot is taken and removed when (destination AND mask) equals (pattern AND mask). It is forwarded unchanged and not taken otherwise.
- R5: An occupied mode-2 slot from another sender is taken by every stop and also forwarded unchanged.
- R6: An occupied mode-3 slot is taken when it matches the pattern under the mask. It is forwarded unchanged whether or not it matches.
- R7: While status bit 0 (receive full) is 1, no slot is taken, the receive registers keep their contents, and every slot is forwarded unchanged.
- R8: Writing location 0 with bit 0 set clears receive full.
- R9: Writing location 8 makes a message pending, shown as status bit 1. It is placed on ring_o only in a cycle whose outgoing slot is free, as {control from location 5 with bit 7 forced to 1, node_id_i, destination from location 6, data from location 7}, and status bit 1 then clears.
- R10: While a message is pending, writes to locations 5, 6, 7 and 8 have no effect. Their read-back and the injected message keep the earlier values.
- R11: An occupied mode-2 or mode-3 slot whose sender equals node_id_i is not taken and leaves as an all-zero slot.
- R12: A slot freed because its message was taken is available to a pending message in the same cycle.
- R13: Reads return the received control, sender, destination and data at locations 1 to 4, and node_id_i at location 11. The status register carries receive full in bit 0 and pending in bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 12 | Strapped address of this stop |
| ring_i | input | 48 | Slot word from the previous stop |
| ring_o | output | 48 | Registered slot word to the next stop |
| reg_addr_i | input | 4 | Register window location |
| reg_wr_i | input | 1 | Write strobe for the addressed location |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data of the addressed location |

## Verification
The bench targets the places where the forward, remove and inject choices meet. One case is a taken single-receiver message whose slot is refilled by a pending send in the same cycle; a design that checks only the incoming valid bit would stall the send, or would overwrite a message that is still forwarding. Refused deliveries while the receive register is full are checked on both sides: a design that ignores the flag would overwrite the held payload, and one that drops refused slots would lose them from the ring. Further cases cover the mask-limited pattern compare with a single differing masked bit, the sender deleting its own returning group traffic (otherwise it circulates forever or is delivered to itself), and writes to the send registers while a send is pending.

// File: rtl/ring_mail_stop_pkg.sv
package ring_mail_stop_pkg;
  localparam int CTRL_W    = 8;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 16;
  localparam int MSG_W     = CTRL_W + 2 * ADDR_W + DATA_W;
  localparam int VALID_BIT = CTRL_W - 1;

  // register window locations
  localparam int LOC_STAT    = 0;
  localparam int LOC_RX_CTRL = 1;
  localparam int LOC_RX_SRC  = 2;
  localparam int LOC_RX_DST  = 3;
  localparam int LOC_RX_DATA = 4;
  localparam int LOC_TX_CTRL = 5;
  localparam int LOC_TX_DST  = 6;
  localparam int LOC_TX_DATA = 7;
  localparam int LOC_TX_GO   = 8;
  localparam int LOC_PAT     = 9;
  localparam int LOC_MASK    = 10;
  localparam int LOC_NODE    = 11;

  typedef enum logic [1:0] {
    MODE_ADDR = 2'd0,
    MODE_PAT  = 2'd1,
    MODE_ALL  = 2'd2,
    MODE_SET  = 2'd3
  } mode_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [DATA_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/ms_match.sv
module ms_match
  import ring_mail_stop_pkg::*;
(
  input  logic              valid_i,
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] node_id_i,
  input  logic [ADDR_W-1:0] pat_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              rx_full_i,
  output logic              accept_o,
  output logic              consume_o,
  output logic              strip_o
);
  logic multi, own, hit, pat_hit;

  assign multi   = (mode_i == MODE_ALL) || (mode_i == MODE_SET);
  assign own     = valid_i && multi && (src_i == node_id_i);
  assign pat_hit = ((dst_i ^ pat_i) & mask_i) == '0;

  always_comb begin
    unique case (mode_i)
      MODE_ADDR: hit = (dst_i == node_id_i);
      MODE_PAT:  hit = pat_hit;
      MODE_ALL:  hit = 1'b1;
      MODE_SET:  hit = pat_hit;
      default:   hit = 1'b0;
    endcase
  end

  assign accept_o  = valid_i && !own && hit && !rx_full_i;
  assign consume_o = accept_o && !multi;
  assign strip_o   = own;
endmodule

// File: rtl/ms_regs.sv
module ms_regs
  import ring_mail_stop_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int REG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] node_id_i,
  input  logic              accept_i,
  input  msg_t              rx_in_i,
  input  logic              inject_i,
  output logic              rx_full_o,
  output logic              tx_pending_o,
  output msg_t              tx_msg_o,
  output logic [ADDR_W-1:0] pat_o,
  output logic [ADDR_W-1:0] mask_o
);
  msg_t              rx_q;
  logic              rx_full_q, tx_pend_q;
  logic [CTRL_W-1:0] tx_ctrl_q;
  logic [ADDR_W-1:0] tx_dst_q, pat_q, mask_q;
  logic [DATA_W-1:0] tx_data_q;
  logic              release_w, tx_open;

  function automatic logic hit_loc(logic [REG_AW-1:0] a, int loc);
    return a == REG_AW'(loc);
  endfunction

  assign release_w = reg_wr_i && hit_loc(reg_addr_i, LOC_STAT) && reg_wdata_i[0];
  assign tx_open   = reg_wr_i && !tx_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else if (accept_i) begin
      rx_q      <= rx_in_i;
      rx_full_q <= 1'b1;
    end else if (release_w) begin
      rx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ctrl_q <= '0;
      tx_dst_q  <= '0;
      tx_data_q <= '0;
      tx_pend_q <= 1'b0;
    end else begin
      if (tx_open && hit_loc(reg_addr_i, LOC_TX_CTRL)) tx_ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      if (tx_open && hit_loc(reg_addr_i, LOC_TX_DST))  tx_dst_q  <= reg_wdata_i[ADDR_W-1:0];
      if (tx_open && hit_loc(reg_addr_i, LOC_TX_DATA)) tx_data_q <= reg_wdata_i[DATA_W-1:0];
      if (inject_i)                                    tx_pend_q <= 1'b0;
      else if (tx_open && hit_loc(reg_addr_i, LOC_TX_GO)) tx_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      mask_q <= '0;
    end else if (reg_wr_i) begin
      if (hit_loc(reg_addr_i, LOC_PAT))  pat_q  <= reg_wdata_i[ADDR_W-1:0];
      if (hit_loc(reg_addr_i, LOC_MASK)) mask_q <= reg_wdata_i[ADDR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (int'(reg_addr_i))
      LOC_STAT:    reg_rdata_o = REG_DW'({tx_pend_q, rx_full_q});
      LOC_RX_CTRL: reg_rdata_o = REG_DW'(rx_q.ctrl);
      LOC_RX_SRC:  reg_rdata_o = REG_DW'(rx_q.src);
      LOC_RX_DST:  reg_rdata_o = REG_DW'(rx_q.dst);
      LOC_RX_DATA: reg_rdata_o = REG_DW'(rx_q.data);
      LOC_TX_CTRL: reg_rdata_o = REG_DW'(tx_ctrl_q);
      LOC_TX_DST:  reg_rdata_o = REG_DW'(tx_dst_q);
      LOC_TX_DATA: reg_rdata_o = REG_DW'(tx_data_q);
      LOC_PAT:     reg_rdata_o = REG_DW'(pat_q);
      LOC_MASK:    reg_rdata_o = REG_DW'(mask_q);
      LOC_NODE:    reg_rdata_o = REG_DW'(node_id_i);
      default:     reg_rdata_o = '0;
    endcase
  end

  always_comb begin
    tx_msg_o            = '{ctrl: tx_ctrl_q, src: node_id_i, dst: tx_dst_q, data: tx_data_q};
    tx_msg_o.ctrl[VALID_BIT] = 1'b1;
  end

  assign rx_full_o    = rx_full_q;
  assign tx_pending_o = tx_pend_q;
  assign pat_o        = pat_q;
  assign mask_o       = mask_q;

  // R7: a held delivery is never overwritten
  p_rx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_q && !release_w) |=> ($stable(rx_q) && rx_full_q));

  // R10: a pending message is frozen until it leaves
  p_tx_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pend_q |=> ($stable(tx_ctrl_q) && $stable(tx_dst_q) && $stable(tx_data_q)));
endmodule

// File: rtl/ms_slot.sv
module ms_slot
  import ring_mail_stop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  msg_t slot_i,
  input  logic drop_i,
  input  logic tx_pending_i,
  input  msg_t tx_msg_i,
  output logic inject_o,
  output msg_t slot_o
);
  msg_t slot_q, slot_d;
  logic free;

  assign free     = !slot_i.ctrl[VALID_BIT] || drop_i;
  assign inject_o = tx_pending_i && free;

  always_comb begin
    if (inject_o)    slot_d = tx_msg_i;
    else if (drop_i) slot_d = '0;
    else             slot_d = slot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  // R2: traffic not for this stop passes with one cycle of delay
  p_forward_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i.ctrl[VALID_BIT] && !drop_i) |=> (slot_q == $past(slot_i)));

  // R9: an injected slot leaves occupied and carries the local sender
  p_inject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> (slot_q.ctrl[VALID_BIT] && slot_q.src == $past(tx_msg_i.src)));
endmodule

// File: rtl/ring_mail_stop.sv
module ring_mail_stop
  import ring_mail_stop_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int REG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] node_id_i,
  input  logic [MSG_W-1:0]  ring_i,
  output logic [MSG_W-1:0]  ring_o,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o
);
  msg_t              in_m, out_m, tx_msg;
  logic              accept, consume, strip, inject, rx_full, tx_pending;
  logic [ADDR_W-1:0] pat, mask;

  assign in_m   = msg_t'(ring_i);
  assign ring_o = out_m;

  ms_match u_match (
    .valid_i   (in_m.ctrl[VALID_BIT]),
    .mode_i    (mode_e'(in_m.ctrl[1:0])),
    .src_i     (in_m.src),
    .dst_i     (in_m.dst),
    .node_id_i (node_id_i),
    .pat_i     (pat),
    .mask_i    (mask),
    .rx_full_i (rx_full),
    .accept_o  (accept),
    .consume_o (consume),
    .strip_o   (strip)
  );

  ms_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_addr_i   (reg_addr_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .node_id_i    (node_id_i),
    .accept_i     (accept),
    .rx_in_i      (in_m),
    .inject_i     (inject),
    .rx_full_o    (rx_full),
    .tx_pending_o (tx_pending),
    .tx_msg_o     (tx_msg),
    .pat_o        (pat),
    .mask_o       (mask)
  );

  ms_slot u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_i       (in_m),
    .drop_i       (consume || strip),
    .tx_pending_i (tx_pending),
    .tx_msg_i     (tx_msg),
    .inject_o     (inject),
    .slot_o       (out_m)
  );

  // R3: a taken single-receiver message leaves the ring (slot empty or refilled locally)
  p_consume_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume |=> (!out_m.ctrl[VALID_BIT] || out_m.src == node_id_i));

  // R5: copied group traffic keeps moving unchanged
  p_copy_fwd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !consume) |=> (ring_o == $past(ring_i)));

  // R11: returning own group traffic is never delivered locally
  p_strip_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip |-> !accept);

  // R7: no delivery while the receive register is occupied
  p_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full |-> !accept);
endmodule

// File: tb/ring_mail_stop_tb_top.sv
`timescale 1ns/1ps
module ring_mail_stop_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] node_id = 12'h05A;
  logic [47:0] ring_in = '0;
  logic [47:0] ring_out;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int          n_tests = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  ring_mail_stop dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .node_id_i   (node_id),
    .ring_i      (ring_in),
    .ring_o      (ring_out),
    .reg_addr_i  (reg_addr),
    .reg_wr_i    (reg_wr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  function automatic logic [47:0] mk(logic [7:0] c, logic [11:0] s, logic [11:0] d, logic [15:0] x);
    return {c, s, d, x};
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one slot on the ring, then idle; sample after the capturing edge
  task automatic send(logic [47:0] m);
    @(negedge clk) ring_in = m;
    @(posedge clk) #2 ring_in = '0;
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk) #2 reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 ring_o", ring_out, '0);
    rd(0, v); chk("R1 status", v, 0);
    rd(9, v); chk("R1 pattern", v, 0);
    rd(10, v); chk("R1 mask", v, 0);
    rd(11, v); chk("R13 node id", v, 16'h005A);
  endtask

  task automatic t_forward;
    logic [15:0] v;
    logic [47:0] m = mk(8'h80, 12'h200, 12'h111, 16'hA5A5);
    send(m);
    chk("R2 forward", ring_out, m);
    rd(0, v); chk("R2 not taken", v, 0);
  endtask

  task automatic t_addr;
    logic [15:0] v;
    send(mk(8'h80, 12'h200, 12'h05A, 16'h1234));
    chk("R3 removed", ring_out, '0);
    rd(0, v); chk("R3 full", v, 1);
    rd(1, v); chk("R13 rx ctrl", v, 16'h0080);
    rd(2, v); chk("R13 rx src", v, 16'h0200);
    rd(3, v); chk("R13 rx dst", v, 16'h005A);
    rd(4, v); chk("R3 rx data", v, 16'h1234);
    wr(0, 16'h0001);
    rd(0, v); chk("R8 release", v, 0);
  endtask

  task automatic t_pattern;
    logic [15:0] v;
    logic [47:0] m;
    wr(9, 16'h00A0); wr(10, 16'h00F0);
    send(mk(8'h81, 12'h200, 12'h3A7, 16'h0001));
    chk("R4 match removed", ring_out, '0);
    rd(3, v); chk("R4 rx dst", v, 16'h03A7);
    wr(0, 16'h0001);
    m = mk(8'h81, 12'h200, 12'h3B7, 16'h0002);
    send(m);
    chk("R4 miss forwarded", ring_out, m);
    rd(0, v); chk("R4 miss not taken", v, 0);
  endtask

  task automatic t_bcast;
    logic [15:0] v;
    logic [47:0] m = mk(8'h82, 12'h200, 12'hFFF, 16'h7777);
    send(m);
    chk("R5 forwarded", ring_out, m);
    rd(4, v); chk("R5 taken", v, 16'h7777);
    wr(0, 16'h0001);
  endtask

  task automatic t_set;
    logic [15:0] v;
    logic [47:0] m = mk(8'h83, 12'h201, 12'h0A5, 16'h3333);
    send(m);
    chk("R6 hit forwarded", ring_out, m);
    rd(4, v); chk("R6 hit taken", v, 16'h3333);
    wr(0, 16'h0001);
    m = mk(8'h83, 12'h201, 12'h1C5, 16'h4444);
    send(m);
    chk("R6 miss forwarded", ring_out, m);
    rd(0, v); chk("R6 miss not taken", v, 0);
  endtask

  task automatic t_block;
    logic [15:0] v;
    logic [47:0] m = mk(8'h80, 12'h300, 12'h05A, 16'hBBBB);
    send(mk(8'h80, 12'h300, 12'h05A, 16'hAAAA));
    send(m);
    chk("R7 refused forwarded", ring_out, m);
    rd(4, v); chk("R7 held data", v, 16'hAAAA);
    rd(0, v); chk("R7 still full", v, 1);
    wr(0, 16'h0001);
  endtask

  task automatic t_strip;
    logic [15:0] v;
    send(mk(8'h82, 12'h05A, 12'hFFF, 16'h9999));
    chk("R11 deleted", ring_out, '0);
    rd(0, v); chk("R11 not taken", v, 0);
  endtask

  task automatic t_tx;
    logic [15:0] v;
    logic [47:0] busy = mk(8'h80, 12'h200, 12'h111, 16'h0F0F);
    @(negedge clk) ring_in = busy;
    wr(5, 16'h0001); wr(6, 16'h0321); wr(7, 16'hCAFE); wr(8, 16'h0001);
    rd(0, v); chk("R9 pending", v, 16'h0002);
    chk("R9 busy slot kept", ring_out, busy);
    wr(7, 16'h0000); wr(6, 16'h0000);
    rd(7, v); chk("R10 data frozen", v, 16'hCAFE);
    @(negedge clk) ring_in = '0;
    @(posedge clk) #2;
    chk("R9 injected", ring_out, mk(8'h81, 12'h05A, 12'h321, 16'hCAFE));
    rd(0, v); chk("R9 pending cleared", v, 0);
  endtask

  task automatic t_reuse;
    logic [15:0] v;
    logic [47:0] busy = mk(8'h83, 12'h201, 12'hF00, 16'h0F0F);
    wr(9, 16'h0000); wr(10, 16'h0FFF);
    @(negedge clk) ring_in = busy;
    wr(5, 16'h0000); wr(6, 16'h0077); wr(7, 16'h5555); wr(8, 16'h0001);
    @(negedge clk) ring_in = mk(8'h80, 12'h200, 12'h05A, 16'h9999);
    @(posedge clk) #2 ring_in = '0;
    chk("R12 refilled", ring_out, mk(8'h80, 12'h05A, 12'h077, 16'h5555));
    rd(4, v); chk("R12 taken", v, 16'h9999);
    rd(0, v); chk("R12 status", v, 16'h0001);
    wr(0, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_addr();
    t_pattern();
    t_bcast();
    t_set();
    t_block();
    t_strip();
    t_tx();
    t_reuse();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule